// File: doc/BRIEF.md
# Handshaked Serial-to-Parallel Receiver

This block collects a serial word from an external sender and presents it as a parallel word to a processor-side port. A transfer starts when the sender raises a one-cycle ready request while the block is idle. The block answers with a one-cycle acknowledge and then drives a shift strobe back to the sender. The strobe is high for one system clock and low for the next. The sender puts the next bit on the data line after each strobe, and the block samples it at the clock edge that ends the following cycle.

Each sampled bit enters the most significant position of a shift register, and the older bits move one place toward bit 0. After WIDTH samples, the first bit sent sits in bit 0, and the block raises a valid flag. The word waits there until the processor side pulses a load input. The load copies the word onto the parallel output, clears the flag and returns the block to idle. Everything runs on one system clock with an active-low asynchronous reset.

Top module: `ser2par_rx`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, ack_o, sclk_o and word_valid_o are 0 and par_o is all zeros.
- R2: A ready_i level sampled high while idle makes ack_o high for exactly the next clock cycle and no longer.
- R3: The first sclk_o strobe is high in the cycle right after the acknowledge. Each strobe lasts one cycle and is followed by at least one low cycle. A transfer issues exactly WIDTH strobes.
- R4: ser_i is sampled at the clock edge that ends the cycle after each strobe. Each sample enters bit WIDTH-1 and shifts the held bits one place toward bit 0. As a result, the k-th bit sent (k counted from 0) ends up in bit k.
- R5: word_valid_o rises at the edge that takes the final sample and stays high until a load.
- R6: A load_i pulse while word_valid_o is high copies the collected word onto par_o at the next edge. word_valid_o falls at the same edge, and the block becomes idle.
- R7: par_o changes only through R6. A load_i seen while word_valid_o is low has no effect on par_o.
- R8: ready_i is ignored while a transfer is shifting and while word_valid_o is high. During those states ack_o stays low and no further strobes are issued.
- R9: Asserting reset in the middle of a transfer clears par_o, ack_o, sclk_o and word_valid_o at once, without waiting for a clock, and stops the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Transfer request from the sender |
| ser_i | input | 1 | Serial data from the sender |
| load_i | input | 1 | Processor pulse that moves the held word to par_o |
| ack_o | output | 1 | One-cycle acknowledge to the sender |
| sclk_o | output | 1 | Shift strobe to the sender |
| word_valid_o | output | 1 | A complete word is held and waiting for a load |
| par_o | output | WIDTH | Parallel word for the processor |

## Verification
Each result is due a fixed number of edges after its stimulus:
- ack_o goes high one edge after ready_i is sampled.
- The first strobe comes one edge after the acknowledge, and later strobes follow every second edge.
- A bit driven right after a strobe is captured two edges after that strobe began.
- word_valid_o rises at the final capture edge.
- par_o and the cleared flag appear one edge after load_i.

The bench drives all inputs on the falling clock edge and reads the outputs on the next falling edge. Each check therefore falls in the half cycle after the rising edge that should produce its result. Random word values, random wait gaps and random ready noise during shifting are mixed with directed cases. The directed cases cover a load while idle, a load during a transfer, ready pulses while a word is waiting, and a reset in the middle of a transfer.

// File: rtl/ser2par_pkg.sv
package ser2par_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACK   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_FULL  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/ser2par_ctrl.sv
module ser2par_ctrl
  import ser2par_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic load_i,
  output logic ack_o,
  output logic sclk_o,
  output logic valid_o,
  output logic sample_o,
  output logic commit_o
);
  localparam int CNT_W = $clog2(WIDTH) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  rx_state_e state_q, state_d;
  logic phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign sample_o = (state_q == ST_SHIFT) && phase_q;
  assign sclk_o   = (state_q == ST_SHIFT) && !phase_q;
  assign ack_o    = (state_q == ST_ACK);
  assign valid_o  = (state_q == ST_FULL);
  assign commit_o = (state_q == ST_FULL) && load_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ready_i) state_d = ST_ACK;
      ST_ACK:   state_d = ST_SHIFT;
      ST_SHIFT: if (sample_o && cnt_q == LAST) state_d = ST_FULL;
      ST_FULL:  if (load_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      // strobe cycle, then capture cycle
      phase_q <= (state_q == ST_SHIFT) ? ~phase_q : 1'b0;
      if (state_q == ST_ACK) cnt_q <= '0;
      else if (sample_o)     cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ser2par_shift.sv
module ser2par_shift #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] sreg_q;

  generate
    if (WIDTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       sreg_q <= '0;
        else if (sample_i) sreg_q <= ser_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       sreg_q <= '0;
        else if (sample_i) sreg_q <= {ser_i, sreg_q[WIDTH-1:1]};
      end
    end
  endgenerate

  assign word_o = sreg_q;
endmodule

// File: rtl/ser2par_out.sv
module ser2par_out #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       par_o <= '0;
    else if (commit_i) par_o <= word_i;
  end
endmodule

// File: rtl/ser2par_rx.sv
module ser2par_rx #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ready_i,
  input  logic             ser_i,
  input  logic             load_i,
  output logic             ack_o,
  output logic             sclk_o,
  output logic             word_valid_o,
  output logic [WIDTH-1:0] par_o
);
  logic             sample;
  logic             commit;
  logic [WIDTH-1:0] word;

  ser2par_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready_i),
    .load_i  (load_i),
    .ack_o   (ack_o),
    .sclk_o  (sclk_o),
    .valid_o (word_valid_o),
    .sample_o(sample),
    .commit_o(commit)
  );

  ser2par_shift #(.WIDTH(WIDTH)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample),
    .ser_i   (ser_i),
    .word_o  (word)
  );

  ser2par_out #(.WIDTH(WIDTH)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .word_i  (word),
    .par_o   (par_o)
  );
endmodule

// File: rtl/ser2par_rx_chk.sv
module ser2par_rx_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_i,
  input logic             ser_i,
  input logic             load_i,
  input logic             ack_o,
  input logic             sclk_o,
  input logic             word_valid_o,
  input logic [WIDTH-1:0] par_o
);
  logic [31:0] n_strb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     n_strb <= '0;
    else if (ack_o)  n_strb <= '0;
    else if (sclk_o) n_strb <= n_strb + 32'd1;
  end

  p_ack_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(ready_i));
  p_ack_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_ack_to_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> sclk_o);
  p_strobe_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> !sclk_o);
  p_strobe_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_valid_o) |-> (n_strb == 32'(WIDTH)));
  p_valid_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && word_valid_o) |=> !word_valid_o);
  p_par_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && word_valid_o) |=> $stable(par_o));
  p_busy_no_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o || sclk_o) |=> !ack_o);
  p_valid_no_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_o && sclk_o));
endmodule

bind ser2par_rx ser2par_rx_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ser2par_rx_tb.sv
module ser2par_rx_tb;
  localparam int W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ready_i = 1'b0;
  logic ser_i = 1'b0;
  logic load_i = 1'b0;
  logic ack_o, sclk_o, word_valid_o;
  logic [W-1:0] par_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [W-1:0] par_model = '0;

  ser2par_rx #(.WIDTH(W)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_word(input logic [W-1:0] bits_sent);
    logic [W-1:0] w = '0;
    for (int i = 0; i < W; i++) w = {bits_sent[i], w[W-1:1]};
    return w;
  endfunction

  // send one word; bit k of data is sent k-th
  task automatic xfer(input logic [W-1:0] data, input bit noise);
    int idx = 0;
    int strobes = 0;
    int extra_acks = 0;
    @(negedge clk_i); ready_i = 1'b1;
    @(negedge clk_i); ready_i = 1'b0;
    chk(ack_o == 1'b1 && sclk_o == 1'b0, "R2 ack after ready", ack_o, 1);
    for (int c = 0; c < 4 * W + 8; c++) begin
      @(negedge clk_i);
      if (word_valid_o) break;
      if (ack_o) extra_acks++;
      if (sclk_o) begin
        strobes++;
        if (c == 0) chk(1'b1, "R3 first strobe", 1, 1);
        ser_i = (idx < W) ? data[idx] : 1'b0;
        idx++;
      end else if (c == 0) begin
        chk(1'b0, "R3 first strobe", 0, 1);
      end
      ready_i = noise ? 1'($urandom % 2) : 1'b0;
    end
    ready_i = 1'b0;
    chk(strobes == W, "R3 strobe count", strobes, W);
    chk(extra_acks == 0, "R8 ready ignored while shifting", extra_acks, 0);
    chk(word_valid_o == 1'b1, "R5 valid after last bit", word_valid_o, 1);
    chk(par_o == par_model, "R7 par held before load", par_o, par_model);
  endtask

  task automatic deliver(input logic [W-1:0] data);
    int bad_ack = 0;
    int gap = $urandom % 5;
    for (int g = 0; g < gap; g++) begin
      ready_i = 1'($urandom % 2);
      @(negedge clk_i);
      if (ack_o || !word_valid_o) bad_ack++;
    end
    ready_i = 1'b0;
    @(negedge clk_i);
    if (ack_o || !word_valid_o) bad_ack++;
    chk(bad_ack == 0, "R8 ready ignored while full", bad_ack, 0);
    chk(word_valid_o == 1'b1, "R5 valid held until load", word_valid_o, 1);
    load_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0;
    par_model = exp_word(data);
    chk(par_o == par_model, "R4 R6 word delivered", par_o, par_model);
    chk(word_valid_o == 1'b0, "R6 valid cleared", word_valid_o, 0);
    @(negedge clk_i);
    chk(ack_o == 1'b0 && sclk_o == 1'b0, "R6 back to idle", sclk_o, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    #1;
    chk(ack_o == 0 && sclk_o == 0 && word_valid_o == 0 && par_o == 0, "R1 reset", par_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ack_o == 0 && sclk_o == 0 && word_valid_o == 0 && par_o == 0, "R1 after release", par_o, 0);

    // directed: walking patterns
    xfer(4'b0001, 1'b0); deliver(4'b0001);
    xfer(4'b1000, 1'b0); deliver(4'b1000);
    xfer(4'b1111, 1'b0); deliver(4'b1111);
    xfer(4'b0000, 1'b0); deliver(4'b0000);

    // R7: load while idle has no effect
    load_i = 1'b1;
    repeat (2) @(negedge clk_i);
    load_i = 1'b0;
    chk(par_o == par_model && !ack_o, "R7 load when idle", par_o, par_model);

    // R7: load during shifting has no effect
    fork
      xfer(4'b1010, 1'b0);
      begin
        repeat (4) @(negedge clk_i);
        load_i = 1'b1;
        @(negedge clk_i);
        load_i = 1'b0;
        chk(par_o == par_model, "R7 load while shifting", par_o, par_model);
      end
    join
    deliver(4'b1010);

    // random with ready noise
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] d = W'($urandom);
      xfer(d, 1'b1);
      deliver(d);
    end

    // R9: reset in the middle of a transfer
    fork
      begin
        @(negedge clk_i); ready_i = 1'b1;
        @(negedge clk_i); ready_i = 1'b0;
      end
    join
    repeat (4) @(negedge clk_i);
    ser_i = 1'b1;
    #3 rst_ni = 1'b0;
    #1;
    chk(ack_o == 0 && sclk_o == 0 && word_valid_o == 0 && par_o == 0, "R9 async clear", par_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    par_model = '0;
    repeat (6) @(negedge clk_i);
    chk(sclk_o == 0 && word_valid_o == 0, "R9 transfer stopped", sclk_o, 0);
    xfer(4'b0110, 1'b0); deliver(4'b0110);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule